// File: doc/BRIEF.md
# Register-Mapped Serial Port with Transmit and Receive Queues

This block is a byte-oriented asynchronous serial port that sits on a processor's 32-bit register bus. Software queues bytes by writing a transmit data register. It drains received bytes by reading a receive data register. Each of those data registers also reports queue status in bit 31. The queue is full on the transmit side and empty on the receive side. Software can therefore poll with a single access and needs no separate status register.

Each direction has its own enable bit in its own control register. A shared divisor register sets the bit time to divisor + 1 core clocks. The line format is fixed: one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. The receiver oversamples the line sixteen times per bit. It rejects start pulses that do not last to mid-bit, and it rejects frames that end with a low stop bit.

Top module: `mmio_uart`

## Requirements
- R1: After reset the tx line is high. Both queues are empty. Both enable bits read 0. The divisor reads the parameter DIV_RESET (default 15).
- R2: A write to offset 0x00 queues wdata[7:0]. The byte is sent as a low start bit, eight data bits LSB first and a high stop bit. Each bit lasts exactly divisor + 1 clocks.
- R3: A read of offset 0x00 returns bit 31 = 1 when the transmit queue holds 8 entries and 0 otherwise. All other bits read 0.
- R4: A write to offset 0x00 while the transmit queue is full is dropped. The queued bytes are unchanged and no extra frame is sent.
- R5: A read of offset 0x04 returns 0x8000_0000 when the receive queue is empty. Otherwise it returns the oldest byte in bits 7:0 with bit 31 = 0, and that byte is removed. A read of an empty queue removes nothing.
- R6: Bit 0 at offset 0x08 enables the transmitter. While it is 0, no frame starts, the tx line stays high, and queued bytes are kept until it is set.
- R7: Bit 0 at offset 0x0C enables the receiver. While it is 0, frames on the rx line store nothing.
- R8: The receiver samples every max(1, floor((divisor+1)/16)) clocks. It confirms a start bit 8 samples after the falling edge and discards a low pulse that has ended by then.
- R9: A frame whose stop bit samples low is discarded.
- R10: Offset 0x18 holds the divisor. Reads return the register selected by the address one clock after the read strobe. Unmapped offsets read 0.
- R11: A byte that arrives while the receive queue holds 8 entries is discarded. The 8 stored bytes are kept in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one clock per access |
| rd_i | input | 1 | Read strobe, one clock per access |
| rdata_o | output | 32 | Read data, valid the clock after rd_i |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
The hardest case to reach is a full queue on either side while the serial engine is active. That covers a dropped ninth write and a ninth byte arriving at a full receive queue. The bench fills the transmit queue with the transmitter disabled, offers one more byte, then enables the transmitter and decodes exactly eight frames followed by silence. On the receive side it sends nine frames before reading any back. Start-pulse rejection needs a low pulse that ends before mid-bit, so the bench drives one that is only a few clocks long.

// File: rtl/mmio_uart_pkg.sv
// Package: shared register offsets and the receive state encoding.
// Assumes byte addressing with word-aligned offsets.
package mmio_uart_pkg;
    localparam int OFF_TXDATA = 'h00;
    localparam int OFF_RXDATA = 'h04;
    localparam int OFF_TXCTRL = 'h08;
    localparam int OFF_RXCTRL = 'h0C;
    localparam int OFF_DIV    = 'h18;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
// Module: synchronous first-in first-out queue.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are both ignored. A push and a pop in the same clock are allowed.
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic [AW:0]  count;
    logic         do_push, do_pop;

    assign count   = wp - rp;
    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp[AW-1:0]];

    // Write storage on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp[AW-1:0]] <= din;
    end

    // Advance the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH)); // R11
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == (AW+1)'(DEPTH))); // R4
    AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0)); // R5
endmodule

// File: rtl/uart_tx_engine.sv
// Module: serial transmitter that takes bytes from the transmit queue.
// Assumes the queue head is valid whenever fifo_empty is low. A frame in
// progress finishes even if the enable drops.
module uart_tx_engine #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_data,
    output logic             pop,
    output logic             tx_o
);
    localparam int FRAME = 10;

    logic             busy;
    logic [DIV_W-1:0] cyc;
    logic [3:0]       bitn;
    logic [FRAME-1:0] sh;

    assign pop  = en && !busy && !fifo_empty;
    assign tx_o = sh[0];

    // Load a frame, then shift one bit out every div+1 clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cyc  <= '0;
            bitn <= '0;
            sh   <= '1;
        end else if (pop) begin
            busy <= 1'b1;
            cyc  <= '0;
            bitn <= '0;
            sh   <= {1'b1, fifo_data, 1'b0};
        end else if (busy) begin
            if (cyc >= div) begin
                cyc <= '0;
                sh  <= {1'b1, sh[FRAME-1:1]};
                if (bitn == 4'(FRAME-1)) busy <= 1'b0;
                else                      bitn <= bitn + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    AST_TX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy); // R6
    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_o); // R6
endmodule

// File: rtl/uart_rx_engine.sv
// Module: oversampling serial receiver.
// Assumes rx_i is asynchronous; it is synchronised by two flops here.
// Sample interval is max(1, floor((div+1)/16)) clocks. A frame in progress
// is abandoned when the enable drops.
module uart_rx_engine
    import mmio_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             rx_i,
    output logic             push_o,
    output logic [7:0]       data_o
);
    localparam int OSW = DIV_W - 3;

    logic             s1, s2;
    logic [DIV_W:0]   per;
    logic [OSW-1:0]   os_top, os_cnt;
    logic             tick;
    rx_state_e        st;
    logic [3:0]       cnt;
    logic [2:0]       bitn;
    logic             unused_per;

    assign per        = {1'b0, div} + 1'b1;
    assign os_top     = (per[DIV_W:4] == '0) ? '0 : per[DIV_W:4] - 1'b1;
    assign tick       = (os_cnt >= os_top);
    assign unused_per = ^per[3:0];

    // Bring the line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rx_i;
            s2 <= s1;
        end
    end

    // Free-running oversample tick divider.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) os_cnt <= '0;
        else                os_cnt <= os_cnt + 1'b1;
    end

    // Frame state machine: start check at mid-bit, data, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RX_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            data_o <= '0;
            push_o <= 1'b0;
        end else begin
            push_o <= 1'b0;
            if (!en) begin
                st <= RX_IDLE;
            end else if (tick) begin
                case (st)
                    RX_IDLE: if (!s2) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                    RX_START: if (cnt == 4'd7) begin
                        st   <= s2 ? RX_IDLE : RX_DATA;
                        cnt  <= '0;
                        bitn <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    RX_DATA: if (cnt == 4'd15) begin
                        cnt    <= '0;
                        data_o <= {s2, data_o[7:1]};
                        bitn   <= bitn + 1'b1;
                        if (bitn == 3'd7) st <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    default: if (cnt == 4'd15) begin
                        st     <= RX_IDLE;
                        push_o <= s2;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                endcase
            end
        end
    end

    AST_RX_OFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !push_o); // R7
    AST_RX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(s2)); // R9
endmodule

// File: rtl/mmio_uart.sv
// Module: register-mapped serial port top. It decodes the register bus,
// holds the control and divisor registers, and links the queues to the
// serial engines. Assumes single-clock strobes and that wr_i and rd_i
// are never high together.
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DIV_W      = 16,
    parameter int DIV_RESET  = 15,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [31:0]       rdata_o,
    input  logic              rx_i,
    output logic              tx_o
);
    logic             tx_en, rx_en;
    logic [DIV_W-1:0] div_q;
    logic             tx_push, tx_pop, tx_full, tx_empty;
    logic [7:0]       tx_head;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]       rx_head, rx_byte;
    logic [31:0]      rd_mux;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i[31:DIV_W];
    assign tx_push = wr_i && (addr_i == ADDR_W'(OFF_TXDATA));
    assign rx_pop  = rd_i && (addr_i == ADDR_W'(OFF_RXDATA));

    // Control and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
            div_q <= DIV_W'(DIV_RESET);
        end else if (wr_i) begin
            if (addr_i == ADDR_W'(OFF_TXCTRL)) tx_en <= wdata_i[0];
            if (addr_i == ADDR_W'(OFF_RXCTRL)) rx_en <= wdata_i[0];
            if (addr_i == ADDR_W'(OFF_DIV))    div_q <= wdata_i[DIV_W-1:0];
        end
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        if (addr_i == ADDR_W'(OFF_TXDATA))
            rd_mux = {tx_full, 31'b0};
        else if (addr_i == ADDR_W'(OFF_RXDATA))
            rd_mux = rx_empty ? 32'h8000_0000 : {24'b0, rx_head};
        else if (addr_i == ADDR_W'(OFF_TXCTRL))
            rd_mux = {31'b0, tx_en};
        else if (addr_i == ADDR_W'(OFF_RXCTRL))
            rd_mux = {31'b0, rx_en};
        else if (addr_i == ADDR_W'(OFF_DIV))
            rd_mux = 32'(div_q);
    end

    // Register the read result one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_mux;
    end

    uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata_i[7:0]),
        .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty));

    uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty));

    uart_tx_engine #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .div(div_q),
        .fifo_empty(tx_empty), .fifo_data(tx_head), .pop(tx_pop), .tx_o(tx_o));

    uart_rx_engine #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .div(div_q), .rx_i(rx_i),
        .push_o(rx_push), .data_o(rx_byte));

    AST_RX_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop) |=> rx_full); // R11
endmodule

// File: tb/sim_mmio_uart.sv
`timescale 1ns/1ps
module sim_mmio_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] rdata;
    logic        rx = 1'b1;
    logic        tx;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    mmio_uart u0 (.clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .rx_i(rx), .tx_o(tx));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    // Drive one frame on rx, per clocks per bit.
    task automatic send_rx(input logic [7:0] b, input int per, input logic stopb);
        logic [9:0] f;
        f = {stopb, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); rx = f[i];
            repeat (per - 1) @(negedge clk);
        end
        @(negedge clk); rx = 1'b1;
        repeat (per) @(negedge clk);
    endtask

    // Decode one frame from tx; ok=0 on timeout or framing error.
    task automatic get_tx(input int per, output logic [7:0] b, output bit ok);
        int w;
        w = 0; ok = 1'b1; b = '0;
        while (tx !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
        if (w >= 3000) begin ok = 1'b0; return; end
        repeat (per / 2) @(negedge clk);
        if (tx !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (per) @(negedge clk);
            b[i] = tx;
        end
        repeat (per) @(negedge clk);
        if (tx !== 1'b1) ok = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(tx === 1'b1, "R1 tx idle", {31'b0, tx}, 32'h1);
        rd_reg(5'h18, d); chk(d == 32'd15, "R1 divisor", d, 32'd15);
        rd_reg(5'h08, d); chk(d == 0, "R1 tx enable", d, 0);
        rd_reg(5'h0C, d); chk(d == 0, "R1 rx enable", d, 0);
        rd_reg(5'h04, d); chk(d == 32'h8000_0000, "R1 rx empty", d, 32'h8000_0000);
        rd_reg(5'h00, d); chk(d == 0, "R1 tx not full", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr_reg(5'h08, 32'h1); rd_reg(5'h08, d); chk(d == 1, "R10 txctrl", d, 1);
        wr_reg(5'h08, 32'h0);
        wr_reg(5'h0C, 32'h1); rd_reg(5'h0C, d); chk(d == 1, "R10 rxctrl", d, 1);
        wr_reg(5'h0C, 32'h0);
        rd_reg(5'h10, d); chk(d == 0, "R10 unmapped 0x10", d, 0);
        rd_reg(5'h1C, d); chk(d == 0, "R10 unmapped 0x1C", d, 0);
    endtask

    task automatic t_tx_disabled();
        logic [7:0] b; bit ok; bit stayed;
        wr_reg(5'h00, 32'hFFFF_FF3C);
        stayed = 1'b1;
        repeat (300) begin @(negedge clk); if (tx !== 1'b1) stayed = 1'b0; end
        chk(stayed, "R6 line high while disabled", {31'b0, stayed}, 1);
        wr_reg(5'h08, 32'h1);
        get_tx(16, b, ok);
        chk(ok && b == 8'h3C, "R2 R6 kept byte sent", {23'b0, ok, b}, {23'b0, 1'b1, 8'h3C});
        wr_reg(5'h08, 32'h0);
    endtask

    task automatic t_tx_full();
        logic [31:0] d; logic [7:0] b; bit ok; bit quiet;
        for (int i = 0; i < 8; i++) wr_reg(5'h00, 32'(8'h10 + i));
        rd_reg(5'h00, d); chk(d == 32'h8000_0000, "R3 full flag", d, 32'h8000_0000);
        wr_reg(5'h00, 32'h99);
        wr_reg(5'h08, 32'h1);
        for (int i = 0; i < 8; i++) begin
            get_tx(16, b, ok);
            chk(ok && b == 8'(8'h10 + i), "R4 queued order", {23'b0, ok, b}, {23'b0, 1'b1, 8'(8'h10 + i)});
        end
        quiet = 1'b1;
        repeat (400) begin @(negedge clk); if (tx !== 1'b1) quiet = 1'b0; end
        chk(quiet, "R4 dropped write not sent", {31'b0, quiet}, 1);
    endtask

    task automatic t_rx_basic();
        logic [31:0] d;
        wr_reg(5'h0C, 32'h1);
        send_rx(8'hA5, 16, 1'b1);
        rd_reg(5'h04, d); chk(d == 32'h0000_00A5, "R5 rx byte", d, 32'hA5);
        rd_reg(5'h04, d); chk(d == 32'h8000_0000, "R5 popped to empty", d, 32'h8000_0000);
        send_rx(8'h3E, 16, 1'b0);
        rd_reg(5'h04, d); chk(d == 32'h8000_0000, "R9 bad stop discarded", d, 32'h8000_0000);
        @(negedge clk); rx = 1'b0; repeat (3) @(negedge clk); rx = 1'b1;
        repeat (200) @(negedge clk);
        rd_reg(5'h04, d); chk(d == 32'h8000_0000, "R8 short pulse ignored", d, 32'h8000_0000);
        wr_reg(5'h0C, 32'h0);
        send_rx(8'h77, 16, 1'b1);
        wr_reg(5'h0C, 32'h1);
        rd_reg(5'h04, d); chk(d == 32'h8000_0000, "R7 disabled rx ignored", d, 32'h8000_0000);
    endtask

    task automatic t_rx_overflow();
        logic [31:0] d;
        for (int i = 0; i < 9; i++) send_rx(8'(8'h40 + i), 16, 1'b1);
        for (int i = 0; i < 8; i++) begin
            rd_reg(5'h04, d);
            chk(d == 32'(8'h40 + i), "R11 stored order", d, 32'(8'h40 + i));
        end
        rd_reg(5'h04, d); chk(d == 32'h8000_0000, "R11 ninth dropped", d, 32'h8000_0000);
    endtask

    task automatic t_divisor();
        logic [31:0] d; int w; int lowc;
        wr_reg(5'h18, 32'd31);
        rd_reg(5'h18, d); chk(d == 32'd31, "R10 divisor write", d, 32'd31);
        wr_reg(5'h00, 32'hFF);
        w = 0;
        while (tx !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
        lowc = 0;
        while (tx === 1'b0 && lowc < 1000) begin @(negedge clk); lowc++; end
        chk(lowc == 32, "R2 bit time div+1", 32'(lowc), 32'd32);
        repeat (400) @(negedge clk);
        send_rx(8'h5A, 32, 1'b1);
        rd_reg(5'h04, d); chk(d == 32'h5A, "R8 rx at divisor 31", d, 32'h5A);
        wr_reg(5'h18, 32'd15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_tx_disabled();
        t_tx_full();
        t_rx_basic();
        t_rx_overflow();
        t_divisor();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule